// File: doc/BRIEF.md
# Change-Tracking Bitmap for Video Memory and Registers

This block watches every byte write headed for three stores: a 64 KB pattern memory, a 128-byte colour memory and a 32-entry configuration register file. For each write it is given the byte being written and the byte currently held at that location, read back by the memory. A flag bit is raised only when the two differ. Writes that leave the contents unchanged do not raise a flag. The flags live in a packed array of 53 bytes that a renderer can read one byte at a time and clear one byte at a time. This lets the renderer redraw only what changed.

Pattern memory is tracked in 256-byte pages, with 32 flag bytes at indices 0x00 to 0x1F. Colour memory is tracked per byte, with 16 flag bytes at indices 0x20 to 0x2F. Registers are tracked per register, with 4 flag bytes at indices 0x30 to 0x33. One summary byte at index 0x34 carries one bit for each category that changed. After reset every flag byte reads all ones, so the first frame redraws everything.

The write, clear and read pins are plain strobes and indices. No data stream is involved, so there is no valid/ready handshake. Every strobe is taken on the clock edge where it is high and is never stalled. All three write sources and a clear may arrive in the same cycle.

Top module: `mem_change_tracker`

## Requirements
- R1: While reset is low and on the first cycle after it, every flag byte at index 0x00 to 0x34 reads 8'hFF.
- R2: A pattern write whose new byte differs from the stored byte sets bit pat_addr[10:8] of flag byte pat_addr[15:11]. It also sets bit 0 of the summary byte 0x34.
- R3: A pattern write whose new byte equals the stored byte changes no flag byte.
- R4: A colour write whose new byte differs sets bit col_addr[2:0] of flag byte 0x20 + col_addr[6:3] and bit 1 of the summary byte. col_addr[7] is ignored.
- R5: A register write whose new value differs sets bit reg_idx[2:0] of flag byte 0x30 + reg_idx[4:3] and bit 3 of the summary byte.
- R6: Colour or register writes whose new value equals the stored value change no flag byte.
- R7: clr_en with clr_idx zeroes that one flag byte on the next edge. All other bytes are untouched.
- R8: When a clear and a flag set hit the same byte in one cycle, the byte afterwards holds exactly the bits being set.
- R9: rd_idx at 0x35 or above reads 8'h00. clr_idx at 0x35 or above changes nothing.
- R10: Differing writes from all three sources in the same cycle are all recorded, including all three summary bits.
- R11: Flags accumulate: a set bit stays set until its byte is cleared or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; marks everything changed |
| pat_we | input | 1 | Pattern memory byte write strobe |
| pat_addr | input | 16 | Pattern memory byte address |
| pat_wdata | input | 8 | Byte being written to pattern memory |
| pat_rdata | input | 8 | Byte currently stored at pat_addr |
| col_we | input | 1 | Colour memory byte write strobe |
| col_addr | input | 8 | Colour memory address; only bits 6:0 are used |
| col_wdata | input | 8 | Byte being written to colour memory |
| col_rdata | input | 8 | Byte currently stored at col_addr |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 5 | Register index |
| reg_wdata | input | 8 | New register value |
| reg_rdata | input | 8 | Current register value |
| clr_en | input | 1 | Flag byte clear strobe |
| clr_idx | input | 6 | Index of the flag byte to clear |
| rd_idx | input | 6 | Index of the flag byte to read |
| rd_flags | output | 8 | Flag byte at rd_idx (combinational) |

## Verification
Each wrong internal state shows up on rd_flags as soon as the affected byte is selected, in the cycle after the write or clear edge. A wrong bit or byte mapping leaves the expected bit clear and raises a bit in some other byte. A broken compare either flags equal writes or misses real changes. A wrong clear priority loses a set bit. Each wrong state persists until the byte is cleared again, so it can be read at any later point rather than only in one cycle.

// File: rtl/mct_pkg.sv
package mct_pkg;
  // Tracked store geometry
  localparam int PAT_AW     = 16;  // pattern memory address width
  localparam int PAT_SHIFT  = 8;   // log2 of pattern tracking page size
  localparam int COL_AW     = 7;   // colour memory address width
  localparam int COL_PORT_W = 8;   // colour address width at the port
  localparam int REG_IW     = 5;   // register index width

  // Flag array layout, derived
  localparam int PAT_BYTES = (2 ** (PAT_AW - PAT_SHIFT)) / 8;
  localparam int COL_BYTES = (2 ** COL_AW) / 8;
  localparam int REG_BYTES = (2 ** REG_IW) / 8;
  localparam int PAT_BASE  = 0;
  localparam int COL_BASE  = PAT_BASE + PAT_BYTES;
  localparam int REG_BASE  = COL_BASE + COL_BYTES;
  localparam int SUM_IDX   = REG_BASE + REG_BYTES;
  localparam int NUM_BYTES = SUM_IDX + 1;
  localparam int IDX_W     = $clog2(NUM_BYTES);

  // Summary byte bit assignment
  localparam int SUM_PAT_BIT = 0;
  localparam int SUM_COL_BIT = 1;
  localparam int SUM_REG_BIT = 3;

  // Sources feeding the flag store
  typedef enum int {
    SRC_PAT = 0,
    SRC_COL = 1,
    SRC_REG = 2,
    SRC_SUM = 3
  } src_e;
  localparam int NSRC = 4;

  typedef logic [7:0] flag_byte_t;
endpackage

// File: rtl/mct_locator.sv
// Compares new against stored byte and maps the write location to a
// flag byte index and a single-bit mask.
module mct_locator #(
  parameter int AW    = 16,
  parameter int SHIFT = 8,
  parameter int BASE  = 0,
  parameter int IDX_W = 6
) (
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  input  logic [7:0]       rdata,
  output logic             hit,
  output logic [IDX_W-1:0] byte_idx,
  output logic [7:0]       bit_mask
);
  localparam int UW = AW - SHIFT;  // tracked unit number width

  logic [UW-1:0] unit;

  assign unit     = addr[AW-1:SHIFT];
  assign hit      = we && (wdata != rdata);
  assign byte_idx = IDX_W'(BASE) + IDX_W'(unit[UW-1:3]);
  assign bit_mask = 8'(1) << unit[2:0];
endmodule

// File: rtl/mct_flag_store.sv
// Array of flag bytes: reset to all ones, OR-in sets, clear by index
// with set taking precedence, combinational read by index.
module mct_flag_store
  import mct_pkg::*;
#(
  parameter int N_BYTES = NUM_BYTES,
  parameter int IW      = IDX_W,
  parameter int NS      = NSRC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NS-1:0]       src_hit,
  input  logic [NS-1:0][IW-1:0] src_idx,
  input  logic [NS-1:0][7:0]  src_mask,
  input  logic                clr_en,
  input  logic [IW-1:0]       clr_idx,
  input  logic [IW-1:0]       rd_idx,
  output logic [7:0]          rd_data
);
  logic [N_BYTES*8-1:0] flat;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    logic [7:0] q;
    logic [7:0] set_bits;
    logic       clr_hit;

    always_comb begin
      set_bits = '0;
      for (int s = 0; s < NS; s++) begin
        if (src_hit[s] && (src_idx[s] == IW'(i))) begin
          set_bits = set_bits | src_mask[s];
        end
      end
    end

    assign clr_hit = clr_en && (clr_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 8'hFF;
      end else if (clr_hit || (set_bits != 8'h00)) begin
        q <= (clr_hit ? 8'h00 : q) | set_bits;
      end
    end

    assign flat[i*8 +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < N_BYTES; i++) begin
      if (rd_idx == IW'(i)) begin
        rd_data = flat[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/mem_change_tracker.sv
module mem_change_tracker
  import mct_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pat_we,
  input  logic [PAT_AW-1:0]     pat_addr,
  input  logic [7:0]            pat_wdata,
  input  logic [7:0]            pat_rdata,
  input  logic                  col_we,
  input  logic [COL_PORT_W-1:0] col_addr,
  input  logic [7:0]            col_wdata,
  input  logic [7:0]            col_rdata,
  input  logic                  reg_we,
  input  logic [REG_IW-1:0]     reg_idx,
  input  logic [7:0]            reg_wdata,
  input  logic [7:0]            reg_rdata,
  input  logic                  clr_en,
  input  logic [IDX_W-1:0]      clr_idx,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_flags
);
  logic [NSRC-1:0]            hit;
  logic [NSRC-1:0][IDX_W-1:0] idx;
  logic [NSRC-1:0][7:0]       mask;

  mct_locator #(
    .AW(PAT_AW), .SHIFT(PAT_SHIFT), .BASE(PAT_BASE), .IDX_W(IDX_W)
  ) u_pat_loc (
    .we(pat_we), .addr(pat_addr), .wdata(pat_wdata), .rdata(pat_rdata),
    .hit(hit[SRC_PAT]), .byte_idx(idx[SRC_PAT]), .bit_mask(mask[SRC_PAT])
  );

  // Upper colour address bits beyond the memory size are dropped here
  mct_locator #(
    .AW(COL_AW), .SHIFT(0), .BASE(COL_BASE), .IDX_W(IDX_W)
  ) u_col_loc (
    .we(col_we), .addr(col_addr[COL_AW-1:0]), .wdata(col_wdata), .rdata(col_rdata),
    .hit(hit[SRC_COL]), .byte_idx(idx[SRC_COL]), .bit_mask(mask[SRC_COL])
  );

  mct_locator #(
    .AW(REG_IW), .SHIFT(0), .BASE(REG_BASE), .IDX_W(IDX_W)
  ) u_reg_loc (
    .we(reg_we), .addr(reg_idx), .wdata(reg_wdata), .rdata(reg_rdata),
    .hit(hit[SRC_REG]), .byte_idx(idx[SRC_REG]), .bit_mask(mask[SRC_REG])
  );

  // Summary byte: one bit per category that saw a real change this cycle
  always_comb begin
    mask[SRC_SUM]              = 8'h00;
    mask[SRC_SUM][SUM_PAT_BIT] = hit[SRC_PAT];
    mask[SRC_SUM][SUM_COL_BIT] = hit[SRC_COL];
    mask[SRC_SUM][SUM_REG_BIT] = hit[SRC_REG];
  end
  assign hit[SRC_SUM] = hit[SRC_PAT] | hit[SRC_COL] | hit[SRC_REG];
  assign idx[SRC_SUM] = IDX_W'(SUM_IDX);

  mct_flag_store #(
    .N_BYTES(NUM_BYTES), .IW(IDX_W), .NS(NSRC)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .src_hit(hit), .src_idx(idx), .src_mask(mask),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .rd_idx(rd_idx), .rd_data(rd_flags)
  );
endmodule

// File: rtl/mem_change_tracker_chk.sv
module mem_change_tracker_chk
  import mct_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pat_we,
  input logic [PAT_AW-1:0]     pat_addr,
  input logic [7:0]            pat_wdata,
  input logic [7:0]            pat_rdata,
  input logic                  col_we,
  input logic [COL_PORT_W-1:0] col_addr,
  input logic [7:0]            col_wdata,
  input logic [7:0]            col_rdata,
  input logic                  reg_we,
  input logic [REG_IW-1:0]     reg_idx,
  input logic [7:0]            reg_wdata,
  input logic [7:0]            reg_rdata,
  input logic                  clr_en,
  input logic [IDX_W-1:0]      clr_idx,
  input logic [IDX_W-1:0]      rd_idx,
  input logic [7:0]            rd_flags
);
  assert_reset_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && (rd_idx < IDX_W'(NUM_BYTES))) |-> (rd_flags == 8'hFF));

  assert_out_of_range_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx >= IDX_W'(NUM_BYTES)) |-> (rd_flags == 8'h00));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_idx) && !$past(clr_en && (clr_idx == rd_idx)))
      |-> ((rd_flags & $past(rd_flags)) == $past(rd_flags)));

  assert_clear_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && clr_en && (clr_idx == rd_idx) && !pat_we && !col_we && !reg_we)
      && $stable(rd_idx)) |-> (rd_flags == 8'h00));

  assert_equal_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && pat_we && (pat_wdata == pat_rdata) && !col_we && !reg_we && !clr_en)
      && $stable(rd_idx)) |-> $stable(rd_flags));

  assert_reg_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && reg_we && (reg_wdata != reg_rdata))
      && (rd_idx == IDX_W'(SUM_IDX))) |-> rd_flags[SUM_REG_BIT]);
endmodule

bind mem_change_tracker mem_change_tracker_chk u_chk (.*);

// File: tb/mem_change_tracker_tb.sv
module mem_change_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pat_we, col_we, reg_we, clr_en;
  logic [15:0] pat_addr;
  logic [7:0] col_addr;
  logic [4:0] reg_idx;
  logic [7:0] pat_wdata, pat_rdata, col_wdata, col_rdata, reg_wdata, reg_rdata;
  logic [5:0] clr_idx, rd_idx;
  logic [7:0] rd_flags;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_change_tracker u_dut (
    .clk(clk), .rst_n(rst_n),
    .pat_we(pat_we), .pat_addr(pat_addr), .pat_wdata(pat_wdata), .pat_rdata(pat_rdata),
    .col_we(col_we), .col_addr(col_addr), .col_wdata(col_wdata), .col_rdata(col_rdata),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clr_en(clr_en), .clr_idx(clr_idx), .rd_idx(rd_idx), .rd_flags(rd_flags)
  );

  // src: 0 none, 1 pattern, 2 colour, 3 register; addr reused per source
  typedef struct packed {
    logic [1:0]  src;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rd;
    logic        clr;
    logic [5:0]  cidx;
    logic [5:0]  ridx;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 16'h1234, 8'h05, 8'h04, 1'b0, 6'h00, 6'h02, 8'h04, 4'd2},  // R2 page bit
    '{2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 6'h00, 6'h34, 8'h01, 4'd2},  // R2 summary
    '{2'd1, 16'hFFFF, 8'h01, 8'h00, 1'b0, 6'h00, 6'h1F, 8'h80, 4'd2},  // R2 top page
    '{2'd1, 16'h0300, 8'h07, 8'h07, 1'b0, 6'h00, 6'h00, 8'h00, 4'd3},  // R3 equal
    '{2'd1, 16'h1034, 8'h09, 8'h08, 1'b0, 6'h00, 6'h02, 8'h05, 4'd11}, // R11 accumulate
    '{2'd2, 16'h002D, 8'h01, 8'h02, 1'b0, 6'h00, 6'h25, 8'h20, 4'd4},  // R4
    '{2'd2, 16'h008A, 8'h03, 8'h04, 1'b0, 6'h00, 6'h21, 8'h04, 4'd4},  // R4 bit7 ignored
    '{2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 6'h00, 6'h34, 8'h03, 4'd4},  // R4 summary
    '{2'd2, 16'h0010, 8'h5A, 8'h5A, 1'b0, 6'h00, 6'h22, 8'h00, 4'd6},  // R6 colour equal
    '{2'd3, 16'h001B, 8'h01, 8'h00, 1'b0, 6'h00, 6'h33, 8'h08, 4'd5},  // R5
    '{2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 6'h00, 6'h34, 8'h0B, 4'd5},  // R5 summary
    '{2'd3, 16'h0005, 8'h33, 8'h33, 1'b0, 6'h00, 6'h30, 8'h00, 4'd6},  // R6 reg equal
    '{2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 6'h02, 6'h02, 8'h00, 4'd7},  // R7 clear
    '{2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 6'h00, 6'h1F, 8'h80, 4'd7},  // R7 neighbour
    '{2'd1, 16'hF800, 8'h01, 8'h00, 1'b1, 6'h1F, 6'h1F, 8'h01, 4'd8},  // R8 set wins
    '{2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 6'h35, 6'h34, 8'h0B, 4'd9},  // R9 bad clear
    '{2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 6'h00, 6'h3F, 8'h00, 4'd9},  // R9 bad read
    '{2'd3, 16'h0000, 8'h02, 8'h00, 1'b1, 6'h34, 6'h34, 8'h08, 4'd8}   // R8 summary
  };

  task automatic idle();
    pat_we = 0; col_we = 0; reg_we = 0; clr_en = 0;
    pat_addr = '0; col_addr = '0; reg_idx = '0;
    pat_wdata = '0; pat_rdata = '0; col_wdata = '0; col_rdata = '0;
    reg_wdata = '0; reg_rdata = '0; clr_idx = '0;
  endtask

  task automatic check(input string tag, input logic [7:0] exp);
    total++;
    if (rd_flags !== exp) begin
      bad++;
      $display("FAIL %s idx=%h actual=%h expected=%h", tag, rd_idx, rd_flags, exp);
    end
  endtask

  // Read a byte with no stimulus: sampled mid-cycle
  task automatic read_at(input logic [5:0] i, input string tag, input logic [7:0] exp);
    @(negedge clk);
    idle();
    rd_idx = i;
    #1 check(tag, exp);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      idle();
      clr_en = 1; clr_idx = 6'(i);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic check_all_ones(input string tag);
    for (int i = 0; i < 53; i++) begin
      rd_idx = 6'(i);
      #1 check(tag, 8'hFF);
    end
  endtask

  initial begin
    idle();
    rd_idx = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check_all_ones("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check_all_ones("R1 after reset");

    clear_all();

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      idle();
      case (VECS[v].src)
        2'd1: begin pat_we = 1; pat_addr = VECS[v].addr; end
        2'd2: begin col_we = 1; col_addr = VECS[v].addr[7:0]; end
        2'd3: begin reg_we = 1; reg_idx = VECS[v].addr[4:0]; end
        default: ;
      endcase
      pat_wdata = VECS[v].wd; pat_rdata = VECS[v].rd;
      col_wdata = VECS[v].wd; col_rdata = VECS[v].rd;
      reg_wdata = VECS[v].wd; reg_rdata = VECS[v].rd;
      clr_en = VECS[v].clr; clr_idx = VECS[v].cidx;
      read_at(VECS[v].ridx, $sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].exp);
    end

    // R10: three differing writes in one cycle
    @(negedge clk);
    idle();
    pat_we = 1; pat_addr = 16'h2A00; pat_wdata = 8'h11; pat_rdata = 8'h22;
    col_we = 1; col_addr = 8'h7F;    col_wdata = 8'h01; col_rdata = 8'h00;
    reg_we = 1; reg_idx  = 5'h0E;    reg_wdata = 8'hF0; reg_rdata = 8'h0F;
    read_at(6'h05, "R10 pattern", 8'h04);
    read_at(6'h2F, "R10 colour", 8'h80);
    read_at(6'h31, "R10 register", 8'h40);
    read_at(6'h34, "R10 summary", 8'h0B);

    // R1: reset mid-run marks everything again
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all_ones("R1 re-reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule